// File: doc/BRIEF.md
# Nibble-Wide Test Frame Generator

This block drives a 4-bit, one-nibble-per-clock transmit interface with a single Ethernet frame that is fixed at build time. It is meant for bringing up a link: the same frame goes out over and over, so a capture tool or a scope on the PHY side always sees a known packet. The frame starts with a preamble and a start delimiter. The destination and source addresses follow, then a length field and a payload taken from a small computed byte store. Zero bytes pad the payload when it is short, and a CRC-32 check sequence is computed while the frame is being sent and placed at the end.

A mode input picks between two behaviours. In one mode frames repeat back to back, separated only by the inter-frame gap. In the other mode each rising edge of a start strobe sends exactly one frame. A busy flag stays high while a frame or its trailing gap is in progress. Every byte leaves low nibble first, so the nibble stream can feed an MII-style PHY directly.

Top module: `nibble_frame_gen`

## Requirements
- R1: A frame opens with seven octets of 0x55 followed by one octet of 0xD5. Every octet of the frame goes out low nibble first, so the first nibble of a frame is 0x5 and the sixteenth is 0xD.
- R2: After the delimiter come the 6-octet destination address (parameter DST_MAC, most significant octet first) and the 6-octet source address (SRC_MAC, same order). Next comes a 2-octet length field equal to PAYLOAD_LEN, high octet first.
- R3: Payload octet p, for p from 0 to PAYLOAD_LEN-1, equals (PAY_SEED + PAY_STEP*p) mod 256.
- R4: When PAYLOAD_LEN is below MIN_PAYLOAD (46), zero octets follow the payload until the payload plus pad is MIN_PAYLOAD octets long.
- R5: The last four octets are the CRC-32 of everything from the destination address through the pad. The CRC uses the reflected polynomial 0x04C11DB7, starts from all ones and is complemented at the end. The least significant octet is sent first.
- R6: tx_en_o is high from the first preamble nibble through the last check-sequence nibble: 144 nibbles with the default parameters. At every other time it is low, and txd_o is 0 whenever tx_en_o is low.
- R7: In continuous mode, tx_en_o stays low for exactly GAP_NIBBLES (24) clocks between consecutive frames.
- R8: With continuous_i low, each rising edge of start_i seen while idle starts exactly one frame. Edges that arrive while busy is high are dropped, and a start_i held high sends only one frame.
- R9: With continuous_i high, frames repeat without any start_i, and start_i has no effect.
- R10: busy_o rises together with tx_en_o and stays high through the gap. In one-shot mode it is high for exactly one frame plus GAP_NIBBLES clocks (168 clocks by default).
- R11: While rst_n is low, tx_en_o, txd_o and busy_o are all 0, and the block is idle once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| continuous_i | input | 1 | 1: repeat frames back to back; 0: one frame per start edge |
| start_i | input | 1 | Start strobe, acted on at its rising edge in one-shot mode |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable, high during the frame |
| busy_o | output | 1 | High while a frame or its gap is in progress |

## Verification
The hardest condition to reach from the ports is a start edge that arrives in the middle of a frame or its gap. The block must drop that edge and not queue it. The bench gets there by sending strobe pulses whose spacing is shorter than one frame period, by holding the strobe high across a whole frame, and by pulsing the strobe while continuous mode is on. In each case it counts the frames that actually start. The check sequence can only be compared against an independent bit-serial CRC if the bench has a complete capture of a frame, so every nibble of a one-shot frame is recorded and compared region by region.

// File: rtl/nfg_pkg.sv
package nfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_BODY = 3'd2,
        PH_FCS  = 3'd3,
        PH_GAP  = 3'd4
    } phase_e;

    localparam int          PRE_BYTES = 8;
    localparam int          HDR_BYTES = 14;
    localparam int          FCS_BYTES = 4;
    localparam logic [7:0]  PRE_OCTET = 8'h55;
    localparam logic [7:0]  SFD_OCTET = 8'hD5;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

endpackage

// File: rtl/nfg_crc_nibble.sv
module nfg_crc_nibble
    import nfg_pkg::*;
(
    input  logic [31:0] crc_i,
    input  logic [3:0]  nib_i,
    output logic [31:0] crc_o
);
    logic [31:0] stage [0:4];

    assign stage[0] = crc_i ^ {28'h0, nib_i};

    for (genvar b = 0; b < 4; b++) begin : g_bit
        assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ CRC_POLY_REFL)
                                        :  (stage[b] >> 1);
    end

    assign crc_o = stage[4];
endmodule

// File: rtl/nfg_body_rom.sv
module nfg_body_rom
    import nfg_pkg::*;
#(
    parameter logic [47:0] DST_MAC     = 48'h0A1B_2C3D_4E5F,
    parameter logic [47:0] SRC_MAC     = 48'h025A_5A00_0001,
    parameter int          PAYLOAD_LEN = 40,
    parameter logic [7:0]  PAY_SEED    = 8'h30,
    parameter logic [7:0]  PAY_STEP    = 8'h03,
    parameter int          IW          = 6
) (
    input  logic [IW-1:0] idx_i,
    output logic [7:0]    byte_o
);
    localparam logic [15:0] LEN_FIELD = 16'(PAYLOAD_LEN);

    int          pos;
    int          pay_pos;
    logic [47:0] dst_sh;
    logic [47:0] src_sh;

    always_comb begin
        pos     = int'(idx_i);
        pay_pos = pos - HDR_BYTES;
        dst_sh  = DST_MAC >> (8 * (5 - (pos % 6)));
        src_sh  = SRC_MAC >> (8 * (5 - (pos % 6)));
        if (pos < 6) begin
            byte_o = dst_sh[7:0];
        end else if (pos < 12) begin
            byte_o = src_sh[7:0];
        end else if (pos == 12) begin
            byte_o = LEN_FIELD[15:8];
        end else if (pos == 13) begin
            byte_o = LEN_FIELD[7:0];
        end else if (pay_pos < PAYLOAD_LEN) begin
            byte_o = 8'(int'(PAY_SEED) + int'(PAY_STEP) * pay_pos);
        end else begin
            byte_o = 8'h00;
        end
    end
endmodule

// File: rtl/nibble_frame_gen.sv
module nibble_frame_gen
    import nfg_pkg::*;
#(
    parameter logic [47:0] DST_MAC     = 48'h0A1B_2C3D_4E5F,
    parameter logic [47:0] SRC_MAC     = 48'h025A_5A00_0001,
    parameter int          PAYLOAD_LEN = 40,
    parameter logic [7:0]  PAY_SEED    = 8'h30,
    parameter logic [7:0]  PAY_STEP    = 8'h03,
    parameter int          MIN_PAYLOAD = 46,
    parameter int          GAP_NIBBLES = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       continuous_i,
    input  logic       start_i,
    output logic [3:0] txd_o,
    output logic       tx_en_o,
    output logic       busy_o
);
    localparam int PADDED_LEN    = (PAYLOAD_LEN < MIN_PAYLOAD) ? MIN_PAYLOAD : PAYLOAD_LEN;
    localparam int BODY_BYTES    = HDR_BYTES + PADDED_LEN;
    localparam int FRAME_NIBBLES = 2 * (PRE_BYTES + BODY_BYTES + FCS_BYTES);
    localparam int CNT_TOP       = (BODY_BYTES > GAP_NIBBLES) ? BODY_BYTES : GAP_NIBBLES;
    localparam int CW            = $clog2(CNT_TOP + 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_BYTES - 1);
    localparam logic [CW-1:0] BODY_LAST = CW'(BODY_BYTES - 1);
    localparam logic [CW-1:0] FCS_LAST  = CW'(FCS_BYTES - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_NIBBLES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] idx;
        logic          hi;
        logic [31:0]   crc;
        logic          start_prev;
    } gen_state_t;

    gen_state_t s_q, s_d;

    logic [7:0]    body_byte;
    logic [7:0]    cur_byte;
    logic [3:0]    cur_nib;
    logic [31:0]   crc_step;
    logic [31:0]   fcs_word;
    logic [31:0]   fcs_sh;
    logic          line_active;
    logic          start_rise;
    logic [CW-1:0] last_idx;
    phase_e        after_phase;

    nfg_body_rom #(
        .DST_MAC     (DST_MAC),
        .SRC_MAC     (SRC_MAC),
        .PAYLOAD_LEN (PAYLOAD_LEN),
        .PAY_SEED    (PAY_SEED),
        .PAY_STEP    (PAY_STEP),
        .IW          (CW)
    ) u_rom (
        .idx_i  (s_q.idx),
        .byte_o (body_byte)
    );

    nfg_crc_nibble u_crc (
        .crc_i (s_q.crc),
        .nib_i (cur_nib),
        .crc_o (crc_step)
    );

    // Output side: the nibble in flight is a function of the registered state only.
    always_comb begin
        fcs_word = ~s_q.crc;
        fcs_sh   = fcs_word >> {s_q.idx[1:0], 3'b000};
        unique case (s_q.phase)
            PH_PRE:  cur_byte = (s_q.idx == PRE_LAST) ? SFD_OCTET : PRE_OCTET;
            PH_BODY: cur_byte = body_byte;
            PH_FCS:  cur_byte = fcs_sh[7:0];
            default: cur_byte = 8'h00;
        endcase
        cur_nib     = s_q.hi ? cur_byte[7:4] : cur_byte[3:0];
        line_active = (s_q.phase == PH_PRE) || (s_q.phase == PH_BODY) || (s_q.phase == PH_FCS);
    end

    assign txd_o   = line_active ? cur_nib : 4'h0;
    assign tx_en_o = line_active;
    assign busy_o  = (s_q.phase != PH_IDLE);

    // Section bounds for the byte-stepped phases.
    always_comb begin
        unique case (s_q.phase)
            PH_PRE:  begin last_idx = PRE_LAST;  after_phase = PH_BODY; end
            PH_BODY: begin last_idx = BODY_LAST; after_phase = PH_FCS;  end
            PH_FCS:  begin last_idx = FCS_LAST;  after_phase = PH_GAP;  end
            default: begin last_idx = '0;        after_phase = PH_IDLE; end
        endcase
    end

    always_comb begin
        s_d            = s_q;
        s_d.start_prev = start_i;
        start_rise     = start_i & ~s_q.start_prev;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (continuous_i || start_rise) begin
                    s_d.phase = PH_PRE;
                    s_d.idx   = '0;
                    s_d.hi    = 1'b0;
                    s_d.crc   = CRC_INIT;
                end
            end
            PH_PRE, PH_BODY, PH_FCS: begin
                if (s_q.phase == PH_BODY) begin
                    s_d.crc = crc_step;
                end
                s_d.hi = ~s_q.hi;
                if (s_q.hi) begin
                    if (s_q.idx == last_idx) begin
                        s_d.idx   = '0;
                        s_d.phase = after_phase;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (s_q.idx == GAP_LAST) begin
                    s_d.idx = '0;
                    s_d.hi  = 1'b0;
                    if (continuous_i) begin
                        s_d.phase = PH_PRE;
                        s_d.crc   = CRC_INIT;
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, idx: '0, hi: 1'b0, crc: CRC_INIT, start_prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/nfg_checker.sv
module nfg_checker #(
    parameter int FRAME_NIBBLES = 144,
    parameter int GAP_NIBBLES   = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] txd,
    input logic       tx_en,
    input logic       busy
);
    int   hi_cnt_q;
    int   lo_cnt_q;
    logic en_prev_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q  <= 0;
            lo_cnt_q  <= 0;
            en_prev_q <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            en_prev_q <= tx_en;
            if (tx_en) begin
                hi_cnt_q <= en_prev_q ? hi_cnt_q + 1 : 1;
            end else begin
                lo_cnt_q <= en_prev_q ? 1 : lo_cnt_q + 1;
                if (en_prev_q) seen_q <= 1'b1;
            end
        end
    end

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |-> (!tx_en && !busy && txd == 4'h0));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd == 4'h0);

    assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> hi_cnt_q == FRAME_NIBBLES);

    assert_first_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> txd == 4'h5);

    assert_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && seen_q) |-> lo_cnt_q >= GAP_NIBBLES);

    assert_en_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> busy);

    assert_gap_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> busy);
endmodule

bind nibble_frame_gen nfg_checker #(
    .FRAME_NIBBLES (FRAME_NIBBLES),
    .GAP_NIBBLES   (GAP_NIBBLES)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .txd   (txd_o),
    .tx_en (tx_en_o),
    .busy  (busy_o)
);

// File: tb/nibble_frame_gen_tb_top.sv
module nibble_frame_gen_tb_top;
    localparam logic [47:0] T_DST   = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] T_SRC   = 48'h025A_5A00_0001;
    localparam int          T_PLEN  = 40;
    localparam logic [7:0]  T_SEED  = 8'h30;
    localparam logic [7:0]  T_STEP  = 8'h03;
    localparam int          T_MIN   = 46;
    localparam int          T_GAP   = 24;
    localparam int          T_BYTES = 8 + 14 + T_MIN + 4;
    localparam int          T_NIBS  = 2 * T_BYTES;

    typedef struct packed {
        logic cont;
        int   pulses;
        int   spacing;
        int   window;
        int   exp_frames;
        int   exp_gap;
    } scen_t;

    localparam scen_t SCEN [6] = '{
        '{1'b1, 0, 1,  420, 3, T_GAP},
        '{1'b1, 3, 50, 420, 3, T_GAP},
        '{1'b0, 1, 1,  300, 1, 0},
        '{1'b0, 3, 40, 300, 1, 0},
        '{1'b0, 2, 200, 500, 2, 0},
        '{1'b1, 0, 1,  760, 5, T_GAP}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       continuous = 1'b0;
    logic       start = 1'b0;
    logic [3:0] txd;
    logic       tx_en;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_b [0:T_BYTES-1];
    logic [3:0] cap   [0:255];
    int  cap_len = 0;
    int  frame_count = 0;
    int  low_run = 0;
    int  last_gap = 0;
    int  idle_nonzero = 0;
    int  busy_run = 0;
    int  last_busy_run = 0;
    logic prev_en = 1'b0;
    logic prev_busy = 1'b0;

    always #10 clk = ~clk;

    nibble_frame_gen #(
        .DST_MAC     (T_DST),
        .SRC_MAC     (T_SRC),
        .PAYLOAD_LEN (T_PLEN),
        .PAY_SEED    (T_SEED),
        .PAY_STEP    (T_STEP),
        .MIN_PAYLOAD (T_MIN),
        .GAP_NIBBLES (T_GAP)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .continuous_i (continuous),
        .start_i      (start),
        .txd_o        (txd),
        .tx_en_o      (tx_en),
        .busy_o       (busy)
    );

    // Line monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                if (!prev_en) begin
                    frame_count++;
                    last_gap = low_run;
                    cap_len  = 0;
                end
                if (cap_len < 256) cap[cap_len] = txd;
                cap_len++;
                low_run = 0;
            end else begin
                low_run++;
                if (txd != 4'h0) idle_nonzero++;
            end
            if (busy) begin
                busy_run++;
            end else if (prev_busy) begin
                last_busy_run = busy_run;
                busy_run = 0;
            end
            prev_en   = tx_en;
            prev_busy = busy;
        end else begin
            prev_en   = 1'b0;
            prev_busy = 1'b0;
            busy_run  = 0;
            low_run   = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic build_expected();
        logic [31:0] crc;
        logic [47:0] sh;
        logic        fb;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        for (int j = 0; j < 6; j++) begin
            sh = T_DST >> (8 * (5 - j)); exp_b[8 + j]  = sh[7:0];
            sh = T_SRC >> (8 * (5 - j)); exp_b[14 + j] = sh[7:0];
        end
        exp_b[20] = 8'(T_PLEN >> 8);
        exp_b[21] = 8'(T_PLEN);
        for (int p = 0; p < T_MIN; p++)
            exp_b[22 + p] = (p < T_PLEN) ? 8'(int'(T_SEED) + int'(T_STEP) * p) : 8'h00;
        crc = 32'hFFFF_FFFF;
        for (int i = 8; i < 22 + T_MIN; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb  = crc[0] ^ exp_b[i][b];
                crc = crc >> 1;
                if (fb) crc = crc ^ 32'hEDB8_8320;
            end
        end
        crc = ~crc;
        for (int j = 0; j < 4; j++) exp_b[22 + T_MIN + j] = 8'(crc >> (8 * j));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int base;
        build_expected();

        // R11: quiet while in reset
        repeat (3) @(negedge clk);
        check(tx_en == 1'b0 && txd == 4'h0 && busy == 1'b0, "R11", "outputs in reset",
              {tx_en, busy, txd}, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(frame_count == 0 && busy == 1'b0, "R8", "no frame without start", frame_count, 0);

        // One-shot frame, captured nibble by nibble (R1..R6, R10)
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(frame_count == 1, "R8", "one frame per edge", frame_count, 1);
        check(cap_len == T_NIBS, "R6", "frame nibble count", cap_len, T_NIBS);
        check(last_busy_run == T_NIBS + T_GAP, "R10", "busy span", last_busy_run, T_NIBS + T_GAP);
        for (int i = 0; i < T_BYTES; i++) begin
            string req;
            if (i < 8) req = "R1";
            else if (i < 22) req = "R2";
            else if (i < 22 + T_PLEN) req = "R3";
            else if (i < 22 + T_MIN) req = "R4";
            else req = "R5";
            check(cap[2*i] == exp_b[i][3:0], req, $sformatf("octet %0d low nibble", i),
                  cap[2*i], exp_b[i][3:0]);
            check(cap[2*i+1] == exp_b[i][7:4], req, $sformatf("octet %0d high nibble", i),
                  cap[2*i+1], exp_b[i][7:4]);
        end

        // R8: strobe held high across a frame sends one frame
        base = frame_count;
        start = 1'b1;
        repeat (400) @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(frame_count - base == 1, "R8", "held strobe", frame_count - base, 1);

        // Scenario table: R7, R8, R9
        foreach (SCEN[k]) begin
            base = frame_count;
            for (int i = 0; i < SCEN[k].window; i++) begin
                @(negedge clk);
                continuous = SCEN[k].cont;
                start = (SCEN[k].pulses > 0) && (i % SCEN[k].spacing == 0) &&
                        (i / SCEN[k].spacing < SCEN[k].pulses);
            end
            @(negedge clk);
            continuous = 1'b0;
            start = 1'b0;
            wait_idle();
            repeat (3) @(negedge clk);
            check(frame_count - base == SCEN[k].exp_frames, SCEN[k].cont ? "R9" : "R8",
                  $sformatf("scenario %0d frame count", k), frame_count - base, SCEN[k].exp_frames);
            if (SCEN[k].exp_gap != 0)
                check(last_gap == SCEN[k].exp_gap, "R7", $sformatf("scenario %0d gap", k),
                      last_gap, SCEN[k].exp_gap);
        end

        // R11: reset in mid-frame returns to idle
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0 && txd == 4'h0 && busy == 1'b0, "R11", "mid-frame reset",
              {tx_en, busy, txd}, 0);
        rst_n = 1'b1;
        base = frame_count;
        repeat (60) @(negedge clk);
        check(frame_count == base && busy == 1'b0, "R11", "idle after reset", frame_count - base, 0);

        check(idle_nonzero == 0, "R6", "txd nonzero while tx_en low", idle_nonzero, 0);
        finish_run();
    end
endmodule